// File: doc/BRIEF.md
# One-Shot Timeout Timer

This block is a single software-programmed countdown that fires once. Software writes one 32-bit control word. Bit 31 of that word is the run bit, and bits 26:0 hold a tick count. The count is measured in device clock ticks: a single-cycle `tick` strobe, nominally 60 MHz, generated outside the block. A write with the run bit set starts the countdown, or starts it again from the new count. A write with the run bit clear stops it quietly.

When the countdown runs out, the block clears the stored word to zero and emits a one-cycle `timeout_pulse`. This pulse goes to an interrupt aggregator, which latches it into its pending register as source bit 16. Masking the interrupt and generating the tick are handled elsewhere.

The control FSM has three states:

- `ST_IDLE`: nothing is counting.
- `ST_ARMED`: a count is in progress.
- `ST_FIRE`: the single cycle in which the pulse is driven.

It has five transitions:

- T_ARM: `ST_IDLE` to `ST_ARMED`, on a write with the run bit set.
- T_RELOAD: `ST_ARMED` to `ST_ARMED`, on a write with the run bit set.
- T_CANCEL: `ST_ARMED` to `ST_IDLE`, on a write with the run bit clear.
- T_EXPIRE: `ST_ARMED` to `ST_FIRE`, on a tick while the remaining count is zero and no write is present.
- T_RETIRE: `ST_FIRE` to `ST_IDLE` on the next cycle, or to `ST_ARMED` if that cycle carries a write with the run bit set.

Top module: `ost_timer`

## Requirements
- R1: After reset, `rd_data` is 0 and `timeout_pulse` is low.
- R2: A write with bit 31 set arms the timer with count N taken from bits 26:0. `timeout_pulse` rises in the cycle after the clock edge that samples the (N+1)-th tick following the write.
- R3: A count of zero with bit 31 set expires on the first tick after the write.
- R4: A write with bit 31 set while a countdown is running discards the old count and restarts with the newly written count.
- R5: A write with bit 31 clear cancels any countdown, and no `timeout_pulse` follows.
- R6: From the cycle after a write, `rd_data` returns the full 32-bit written word until an expiry.
- R7: From the cycle in which `timeout_pulse` is high, `rd_data` reads 0.
- R8: `timeout_pulse` is high for exactly one cycle per expiry.
- R9: A write and a tick in the same cycle: the write takes effect and the tick is ignored.
- R10: Ticks while the timer is not armed have no effect on `rd_data` or `timeout_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Written word: bit 31 is the run bit, bits 26:0 are the count |
| rd_data | output | 32 | Stored register value |
| tick | input | 1 | One-cycle device clock tick strobe |
| timeout_pulse | output | 1 | One-cycle expiry strobe toward the interrupt aggregator |

## Verification
The assertions assume that `wr_en`, `wr_data` and `tick` are driven cleanly, with known values in every cycle after reset. They also assume that `tick` is a strobe sampled on the block clock rather than a free clock, so a tick on every cycle is legal.

The random stimulus holds these inputs stable between falling edges. It uses only small counts (0 to 15) so that expiries actually occur. Writes are sparse enough that many countdowns complete, but frequent enough that writes collide with ticks and with the fire cycle.

// File: rtl/ost_pkg.sv
package ost_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } ost_state_e;
endpackage

// File: rtl/ost_fsm.sv
module ost_fsm
    import ost_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_arm,
    input  logic       wr_stop,
    input  logic       tick,
    input  logic       cnt_zero,
    output logic       load,
    output logic       dec,
    output logic       expire,
    output logic       pulse
);
    ost_state_e state_q, state_d;
    logic       wr_any;

    assign wr_any = wr_arm | wr_stop;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_arm) state_d = ST_ARMED;                 // T_ARM
            end
            ST_ARMED: begin
                if (wr_arm)                 state_d = ST_ARMED; // T_RELOAD
                else if (wr_stop)           state_d = ST_IDLE;  // T_CANCEL
                else if (tick && cnt_zero)  state_d = ST_FIRE;  // T_EXPIRE
            end
            ST_FIRE: begin
                state_d = wr_arm ? ST_ARMED : ST_IDLE;          // T_RETIRE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load   = wr_arm;
        dec    = 1'b0;
        expire = 1'b0;
        pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: begin
                dec    = tick && !wr_any && !cnt_zero;
                expire = tick && !wr_any &&  cnt_zero;
            end
            ST_FIRE:  pulse = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/ost_store.sv
module ost_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear,
    output logic [DATA_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)     value <= '0;
        else if (wr_en) value <= wr_data;
        else if (clear) value <= '0;
    end
endmodule

// File: rtl/ost_timer.sv
module ost_timer #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 27,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              timeout_pulse
);
    logic wr_arm, wr_stop, load, dec, expire, cnt_zero;

    assign wr_arm  = wr_en &&  wr_data[EN_BIT];
    assign wr_stop = wr_en && !wr_data[EN_BIT];

    ost_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_arm   (wr_arm),
        .wr_stop  (wr_stop),
        .tick     (tick),
        .cnt_zero (cnt_zero),
        .load     (load),
        .dec      (dec),
        .expire   (expire),
        .pulse    (timeout_pulse)
    );

    ost_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data[CNT_W-1:0]),
        .dec      (dec),
        .cnt_zero (cnt_zero)
    );

    ost_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clear   (expire),
        .value   (rd_data)
    );
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
    parameter int DATA_W = 32,
    parameter int EN_BIT = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              tick,
    input logic              timeout_pulse
);
    assert_write_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    assert_cancel_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> !timeout_pulse);

    assert_fire_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> rd_data == '0);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    assert_write_beats_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !timeout_pulse);

    assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> $past(tick));
endmodule

bind ost_timer ost_checker #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .tick          (tick),
    .timeout_pulse (timeout_pulse)
);

// File: tb/sim_ost_timer.sv
module sim_ost_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic        timeout_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_val = '0;
    logic        m_armed = 1'b0;
    logic [26:0] m_cnt = '0;
    logic        m_pulse = 1'b0;

    always #5 clk = ~clk;

    ost_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .timeout_pulse(timeout_pulse)
    );

    function automatic bit fires(bit armed, logic [26:0] cnt, bit tk, bit wr);
        return armed && tk && !wr && (cnt == 0);
    endfunction

    function automatic logic [26:0] next_cnt(bit armed, logic [26:0] cnt, bit tk);
        return (armed && tk && cnt != 0) ? cnt - 1'b1 : cnt;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(bit wr, logic [31:0] d, bit tk, string tag);
        wr_en = wr; wr_data = d; tick = tk;
        @(posedge clk);
        m_pulse = fires(m_armed, m_cnt, tk, wr);
        if (wr) begin
            m_val = d; m_armed = d[31]; m_cnt = d[26:0];
        end else if (m_pulse) begin
            m_val = '0; m_armed = 1'b0;
        end else begin
            m_cnt = next_cnt(m_armed, m_cnt, tk);
        end
        @(negedge clk);
        check({tag, " rd_data"}, rd_data, m_val);
        check({tag, " pulse"}, {31'd0, timeout_pulse}, {31'd0, m_pulse});
        wr_en = 1'b0; tick = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 32'd0);
        check("R1 reset pulse", {31'd0, timeout_pulse}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: ticks while idle
        for (int i = 0; i < 4; i++) step(1'b0, 32'd0, 1'b1, "R10");

        // R3: zero count expires on first tick
        step(1'b1, 32'h8000_0000, 1'b0, "R6");
        step(1'b0, 32'd0, 1'b1, "R3");
        check("R7 cleared after expiry", rd_data, 32'd0);
        step(1'b0, 32'd0, 1'b0, "R8");

        // R2: count 3 expires after 4 ticks, upper bits read back
        step(1'b1, 32'hF800_0003, 1'b0, "R6");
        for (int i = 0; i < 3; i++) step(1'b0, 32'd0, 1'b1, "R2");
        check("R6 hold until expiry", rd_data, 32'hF800_0003);
        step(1'b0, 32'd0, 1'b0, "R2");
        step(1'b0, 32'd0, 1'b1, "R2");
        check("R2 pulse at 4th tick", {31'd0, timeout_pulse}, 32'd1);

        // R4: restart mid-count
        step(1'b1, 32'h8000_0005, 1'b1, "R4");
        step(1'b0, 32'd0, 1'b1, "R4");
        step(1'b1, 32'h8000_0002, 1'b0, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 32'd0, 1'b1, "R4");

        // R5: cancel, then ticks give no pulse
        step(1'b1, 32'h8000_0001, 1'b0, "R5");
        step(1'b1, 32'h0000_0001, 1'b1, "R5");
        for (int i = 0; i < 5; i++) step(1'b0, 32'd0, 1'b1, "R5");
        check("R5 value kept after cancel", rd_data, 32'h0000_0001);

        // R9: write with tick when count zero, tick ignored
        step(1'b1, 32'h8000_0000, 1'b0, "R9");
        step(1'b1, 32'h8000_0000, 1'b1, "R9");
        check("R9 no pulse on write+tick", {31'd0, timeout_pulse}, 32'd0);
        step(1'b0, 32'd0, 1'b1, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit wr = ($urandom_range(0, 9) == 0);
            bit tk = $urandom_range(0, 1);
            logic [31:0] d = $urandom;
            d[26:0] = 27'($urandom_range(0, 15));
            step(wr, d, tk, "R2 R4 R5 R8 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule